// File: doc/BRIEF.md
# SPI Command Host Register Front End

This block sits between a host processor and a command-driven SPI execution engine. The host uses a simple 32-bit register port that completes in one cycle. Through it the host pushes 16-bit command words and 8-bit transmit bytes into two queues, and it pulls received bytes out of a third queue. It can read how much room each outbound queue has left and how full the inbound queue is. It also holds the engine in reset, reads a version word and services a four-source interrupt. The engine, which is not part of this block, drains the outbound queues and fills the inbound queue through valid/ready streams. When the engine reaches a sync command it sends a strobe that carries an 8-bit identifier.

All three engine-side streams follow the usual rules. A word moves only in a cycle where both valid and ready are high. Once the block raises `cmd_valid` or `tx_valid`, that valid and its data stay unchanged until the engine accepts the word. `rx_ready` falls while the receive queue is full, and while the soft reset holds the engine. A byte offered in such a cycle is not taken. The engine must keep it until `rx_ready` returns.

Register port timing: `reg_rdata` is combinational and is valid in the cycle where `reg_rd` is high. Side effects take place at the next rising edge: a pop on the receive read address, a push on the two write addresses, and every register write. When `reg_rd` is low, `reg_rdata` is zero.

Top module: `spi_cmd_host_regs`

## Requirements
- R1: After `rst_n` is released, the following hold. The soft reset register (0x40) reads 1 and `core_rst` is high. Both room registers read the queue depth (16 by default). The receive level reads 0. The enable and pending registers read 0, and `irq` is low.
- R2: Address 0x00 reads 0x0001_0061 by default. Bits [23:16] hold the major number, which is always 1. Bits [15:8] hold the minor number and bits [7:0] the patch number; both are parameters.
- R3: Address 0x40, bit 0, is the soft reset. Writing 1 drives `core_rst` high. From the following edge, all three queues are empty: `cmd_valid`, `tx_valid` and `rx_ready` are low, and pushes from either side are ignored. Writing 0 releases the soft reset. The register reads back what was written.
- R4: A write to 0xE0 pushes `reg_wdata[15:0]` into the command queue. The engine receives the words in push order on `cmd_data`. A word is removed when `cmd_valid && cmd_ready`. While `cmd_ready` is low, the word stays on `cmd_data` unchanged.
- R5: A write to 0xE4 pushes `reg_wdata[7:0]` into the transmit queue. The queue is presented on `tx_valid`/`tx_ready`/`tx_data` under the same rules as R4.
- R6: The engine adds a byte to the receive queue when `rx_valid && rx_ready`. A read of 0xE8 returns the oldest byte in bits [7:0] and removes it. A read of 0xEC returns the same byte and does not remove it.
- R7: Address 0xD0 reads the free entries of the command queue. Address 0xD4 reads the free entries of the transmit queue. Address 0xD8 reads the number of bytes in the receive queue.
- R8: A push into a full queue is dropped, and `rx_ready` is low while the receive queue is full. A read of 0xE8 or 0xEC on an empty receive queue returns 0 and changes nothing.
- R9: The interrupt bits are assigned as follows.
  - Bit 0 is true while the command level ≤ the command low mark (default 4).
  - Bit 1 is true while the transmit level ≤ the transmit low mark (default 4).
  - Bit 2 is true while the receive level ≥ the receive high mark (default 12).
  - Bit 3 is the sync event.

  The pending bit of a level source is set at the second edge after the level crosses into the true state. Starting state does not count as a crossing, so no bit is pending after reset.
- R10: Bits [3:0] of 0x80 are the enable register. `irq` is the OR of pending AND enable. A read of 0x88 returns pending AND enable. Writing 1 to a bit of 0x84 clears that pending bit. If a set and a clear of the same bit fall in the same cycle, the set wins.
- R11: A `sync_valid` strobe has two effects at the next edge: it loads `sync_id` into the register at 0xC0, and it sets pending bit 3.
- R12: Unmapped addresses read 0. Writes to read-only addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Interrupt request |
| core_rst | output | 1 | Soft reset to the engine |
| cmd_valid | output | 1 | Command word available |
| cmd_ready | input | 1 | Engine takes the command word |
| cmd_data | output | 16 | Command word |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Engine takes the transmit byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Engine offers a received byte |
| rx_ready | output | 1 | Receive queue accepts a byte |
| rx_data | input | 8 | Received byte |
| sync_valid | input | 1 | Sync event strobe |
| sync_id | input | 8 | Identifier of the sync event |

## Verification
Each kind of internal fault shows at the ports within a few cycles:
- A wrong queue count shows on the next read of a room or level register. It also shows on the next transfer, as a `cmd_valid` or `tx_valid` that drops early, or as an `rx_ready` that stays low.
- A wrong read or write pointer shows as a word out of order on the first pop after the error.
- A wrong edge-detect state shows two edges after a level crossing, as an `irq` that appears without cause or never appears.
- A lost sync capture shows on the next read of 0xC0.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam logic [7:0] A_VERSION  = 8'h00;
  localparam logic [7:0] A_SOFTRST  = 8'h40;
  localparam logic [7:0] A_IRQ_EN   = 8'h80;
  localparam logic [7:0] A_IRQ_PEND = 8'h84;
  localparam logic [7:0] A_IRQ_SRC  = 8'h88;
  localparam logic [7:0] A_SYNC     = 8'hC0;
  localparam logic [7:0] A_CMD_ROOM = 8'hD0;
  localparam logic [7:0] A_TX_ROOM  = 8'hD4;
  localparam logic [7:0] A_RX_LVL   = 8'hD8;
  localparam logic [7:0] A_CMD_PUSH = 8'hE0;
  localparam logic [7:0] A_TX_PUSH  = 8'hE4;
  localparam logic [7:0] A_RX_POP   = 8'hE8;
  localparam logic [7:0] A_RX_PEEK  = 8'hEC;

  localparam int unsigned N_LVL_SRC = 3;
  localparam int unsigned N_IRQ     = N_LVL_SRC + 1;
  localparam logic [7:0]  VER_MAJOR = 8'd1;
endpackage

// File: rtl/spi_host_fifo.sv
module spi_host_fifo #(
  parameter int unsigned W  = 8,
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [AW:0]   level
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          is_full, is_empty, do_push, do_pop;

  assign is_full  = (level == (AW+1)'(DEPTH));
  assign is_empty = (level == '0);
  assign do_push  = push && !is_full && !flush;
  assign do_pop   = pop && !is_empty && !flush;
  assign dout     = is_empty ? '0 : mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/spi_host_irq.sv
module spi_host_irq #(
  parameter int unsigned  NL      = 3,
  parameter logic [NL-1:0] LVL_RST = '0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [NL-1:0] lvl,
  input  logic        evt,
  input  logic        en_we,
  input  logic        clr_we,
  input  logic [NL:0] wdata,
  output logic [NL:0] enable,
  output logic [NL:0] pending,
  output logic        irq
);
  logic [NL-1:0] lvl_q;
  logic [NL:0]   set_v, clr_v;

  assign set_v = {evt, lvl & ~lvl_q};
  assign clr_v = clr_we ? wdata : '0;
  assign irq   = |(pending & enable);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= LVL_RST;
      pending <= '0;
      enable  <= '0;
    end else begin
      lvl_q   <= lvl;
      pending <= (pending & ~clr_v) | set_v;
      if (en_we) enable <= wdata;
    end
  end
endmodule

// File: rtl/spi_cmd_host_regs.sv
module spi_cmd_host_regs
  import spi_host_pkg::*;
#(
  parameter int unsigned CMD_AW    = 4,
  parameter int unsigned TX_AW     = 4,
  parameter int unsigned RX_AW     = 4,
  parameter int unsigned CMD_LOW   = (1 << CMD_AW) / 4,
  parameter int unsigned TX_LOW    = (1 << TX_AW) / 4,
  parameter int unsigned RX_HIGH   = 3 * (1 << RX_AW) / 4,
  parameter logic [7:0]  VER_MINOR = 8'h00,
  parameter logic [7:0]  VER_PATCH = 8'h61
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        core_rst,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [15:0] cmd_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data,
  input  logic        sync_valid,
  input  logic [7:0]  sync_id
);
  localparam int unsigned CMD_DEPTH = 1 << CMD_AW;
  localparam int unsigned TX_DEPTH  = 1 << TX_AW;
  localparam int unsigned RX_DEPTH  = 1 << RX_AW;

  logic              soft_rst;
  logic [7:0]        sync_q;
  logic [CMD_AW:0]   cmd_level;
  logic [TX_AW:0]    tx_level;
  logic [RX_AW:0]    rx_level;
  logic [7:0]        rx_head;
  logic [N_IRQ-1:0]  irq_en, irq_pend;
  logic [N_LVL_SRC-1:0] lvl_cond;
  logic              wr_cmd, wr_tx, rd_pop, rx_push;

  assign wr_cmd  = reg_wr && (reg_addr == A_CMD_PUSH);
  assign wr_tx   = reg_wr && (reg_addr == A_TX_PUSH);
  assign rd_pop  = reg_rd && (reg_addr == A_RX_POP);
  assign rx_ready = !soft_rst && (32'(rx_level) < RX_DEPTH);
  assign rx_push  = rx_valid && rx_ready;
  assign core_rst = soft_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_rst <= 1'b1;
      sync_q   <= '0;
    end else begin
      if (reg_wr && reg_addr == A_SOFTRST) soft_rst <= reg_wdata[0];
      if (sync_valid) sync_q <= sync_id;
    end
  end

  spi_host_fifo #(.W(16), .AW(CMD_AW)) u_cmd_q (
    .clk(clk), .rst_n(rst_n), .flush(soft_rst),
    .push(wr_cmd), .din(reg_wdata[15:0]),
    .pop(cmd_ready), .dout(cmd_data), .level(cmd_level)
  );

  spi_host_fifo #(.W(8), .AW(TX_AW)) u_tx_q (
    .clk(clk), .rst_n(rst_n), .flush(soft_rst),
    .push(wr_tx), .din(reg_wdata[7:0]),
    .pop(tx_ready), .dout(tx_data), .level(tx_level)
  );

  spi_host_fifo #(.W(8), .AW(RX_AW)) u_rx_q (
    .clk(clk), .rst_n(rst_n), .flush(soft_rst),
    .push(rx_push), .din(rx_data),
    .pop(rd_pop), .dout(rx_head), .level(rx_level)
  );

  assign cmd_valid = (cmd_level != '0);
  assign tx_valid  = (tx_level != '0);

  assign lvl_cond[0] = (32'(cmd_level) <= CMD_LOW);
  assign lvl_cond[1] = (32'(tx_level) <= TX_LOW);
  assign lvl_cond[2] = (32'(rx_level) >= RX_HIGH);

  spi_host_irq #(.NL(N_LVL_SRC), .LVL_RST(3'b011)) u_irq (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_cond), .evt(sync_valid),
    .en_we(reg_wr && reg_addr == A_IRQ_EN),
    .clr_we(reg_wr && reg_addr == A_IRQ_PEND),
    .wdata(reg_wdata[N_IRQ-1:0]),
    .enable(irq_en), .pending(irq_pend), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        A_VERSION:  reg_rdata = {8'd0, VER_MAJOR, VER_MINOR, VER_PATCH};
        A_SOFTRST:  reg_rdata = {31'd0, soft_rst};
        A_IRQ_EN:   reg_rdata = 32'(irq_en);
        A_IRQ_PEND: reg_rdata = 32'(irq_pend);
        A_IRQ_SRC:  reg_rdata = 32'(irq_pend & irq_en);
        A_SYNC:     reg_rdata = {24'd0, sync_q};
        A_CMD_ROOM: reg_rdata = CMD_DEPTH - 32'(cmd_level);
        A_TX_ROOM:  reg_rdata = TX_DEPTH - 32'(tx_level);
        A_RX_LVL:   reg_rdata = 32'(rx_level);
        A_RX_POP,
        A_RX_PEEK:  reg_rdata = {24'd0, rx_head};
        default:    reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/spi_cmd_host_regs_chk.sv
module spi_cmd_host_regs_chk #(
  parameter int unsigned RX_DEPTH = 16,
  parameter int unsigned RX_LW    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [7:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic [31:0]      reg_rdata,
  input logic             core_rst,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [15:0]      cmd_data,
  input logic             tx_valid,
  input logic             rx_ready,
  input logic             sync_valid,
  input logic [7:0]       sync_id,
  input logic [7:0]       sync_q,
  input logic [RX_LW-1:0] rx_level
);
  logic rst_wr1;
  assign rst_wr1 = reg_wr && reg_addr == 8'h40 && reg_wdata[0];

  // R2: major number reads 1
  a_r2_major_one: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 8'h00) |-> reg_rdata[23:16] == 8'd1);

  // R3: held engine sees empty queues from the next edge
  a_r3_flush_on_hold: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |=> (!cmd_valid && !tx_valid));

  // R4: stalled command word stays put
  a_r4_cmd_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !core_rst && !rst_wr1) |=> (cmd_valid && $stable(cmd_data)));

  // R8: empty receive read returns zero, level never above depth
  a_r8_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 8'hE8 && rx_level == '0) |-> reg_rdata == 32'd0);
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rx_level) <= RX_DEPTH);

  // R11: sync identifier captured on the strobe
  a_r11_sync_capture: assert property (@(posedge clk) disable iff (!rst_n)
    sync_valid |=> sync_q == $past(sync_id));
endmodule

bind spi_cmd_host_regs spi_cmd_host_regs_chk #(.RX_DEPTH(1 << RX_AW), .RX_LW(RX_AW + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_rst(core_rst),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
  .tx_valid(tx_valid), .rx_ready(rx_ready), .sync_valid(sync_valid),
  .sync_id(sync_id), .sync_q(sync_q), .rx_level(rx_level)
);

// File: tb/sim_spi_cmd_host_regs.sv
`timescale 1ns/1ps
module sim_spi_cmd_host_regs;
  localparam int CLK_PERIOD = 10;
  localparam int N = 27;
  // op: 0 write, 1 read and compare
  localparam logic        T_OP  [N] = '{1,1,1,1,1,1,1, 0,0,1,1, 0,1, 0,0,1, 0,1, 1,1,1, 1,0,1, 0,1,1};
  localparam logic [7:0]  T_ADR [N] = '{
    8'h40, 8'h00, 8'hD0, 8'hD4, 8'hD8, 8'h84, 8'h80,   // R1 R2 reset state
    8'hE0, 8'hE4, 8'hD0, 8'hD4,                        // R3 pushes while held
    8'h40, 8'h40,                                      // R3 release
    8'hE0, 8'hE0, 8'hD0,                               // R4 R7
    8'hE4, 8'hD4,                                      // R5 R7
    8'hE8, 8'hEC, 8'hD8,                               // R8 empty reads
    8'h1C, 8'hD0, 8'hD0,                               // R12
    8'h80, 8'h80, 8'h88};                              // R10
  localparam logic [31:0] T_DAT [N] = '{
    32'd1, 32'h0001_0061, 32'd16, 32'd16, 32'd0, 32'd0, 32'd0,
    32'h1234, 32'h77, 32'd16, 32'd16,
    32'd0, 32'd0,
    32'hA5A5, 32'h0101, 32'd14,
    32'h3C, 32'd15,
    32'd0, 32'd0, 32'd0,
    32'd0, 32'h55, 32'd14,
    32'hF, 32'hF, 32'd0};
  localparam int T_REQ [N] = '{1,2,1,1,1,1,1, 3,3,3,3, 3,3, 4,4,7, 5,7, 8,8,8, 12,12,12, 10,10,10};

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq, core_rst, cmd_valid, tx_valid, rx_ready;
  logic cmd_ready = 0, tx_ready = 0, rx_valid = 0, sync_valid = 0;
  logic [15:0] cmd_data;
  logic [7:0] tx_data, rx_data = 0, sync_id = 0;
  int n_chk = 0, n_fail = 0;
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cmd_host_regs u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .core_rst(core_rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .sync_valid(sync_valid), .sync_id(sync_id));

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(posedge clk); #1 reg_rd = 0;
  endtask

  task automatic pop_cmd();
    @(negedge clk); cmd_ready = 1; @(posedge clk); #1 cmd_ready = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(irq, 0, "R1 irq low");
    chk(core_rst, 1, "R1 core held");

    for (int i = 0; i < N; i++) begin
      if (T_OP[i]) begin
        bus_rd(T_ADR[i], rd);
        chk(rd, T_DAT[i], $sformatf("R%0d table row %0d", T_REQ[i], i));
      end else begin
        bus_wr(T_ADR[i], T_DAT[i]);
      end
    end

    // R4 stream order and stall stability
    @(negedge clk);
    chk(cmd_valid, 1, "R4 valid");
    chk(cmd_data, 16'hA5A5, "R4 head");
    repeat (3) @(negedge clk);
    chk(cmd_data, 16'hA5A5, "R4 stable while stalled");
    pop_cmd();
    @(negedge clk);
    chk(cmd_data, 16'h0101, "R4 second word");
    pop_cmd();
    @(negedge clk);
    chk(cmd_valid, 0, "R4 drained");

    // R9 low-mark edge and timing, R10 masking and clear
    bus_wr(8'h84, 32'hFF);
    for (int i = 0; i < 5; i++) bus_wr(8'hE0, 32'h10 + i);
    repeat (2) @(negedge clk);
    chk(irq, 0, "R9 above mark");
    pop_cmd();
    @(negedge clk);
    chk(irq, 0, "R9 not yet set");
    @(negedge clk);
    chk(irq, 1, "R9 command low set");
    bus_rd(8'h88, rd); chk(rd, 32'h1, "R10 source");
    bus_wr(8'h80, 32'h0);
    @(negedge clk); chk(irq, 0, "R10 masked");
    bus_rd(8'h84, rd); chk(rd, 32'h1, "R10 still pending");
    bus_wr(8'h84, 32'h1);
    bus_rd(8'h84, rd); chk(rd, 32'h0, "R10 cleared");
    bus_wr(8'h80, 32'hF);
    for (int i = 0; i < 4; i++) pop_cmd();
    @(negedge clk);
    chk(cmd_valid, 0, "R4 all popped");

    // R5 transmit stream
    chk(tx_valid, 1, "R5 valid");
    chk(tx_data, 8'h3C, "R5 data");
    @(negedge clk); tx_ready = 1; @(posedge clk); #1 tx_ready = 0;
    @(negedge clk);
    chk(tx_valid, 0, "R5 drained");

    // R6 R8 R9 receive path
    bus_wr(8'h84, 32'hFF);
    for (int i = 1; i <= 17; i++) begin
      @(negedge clk); rx_valid = 1; rx_data = 8'(i);
      @(posedge clk); #1;
    end
    rx_valid = 0;
    @(negedge clk);
    chk(rx_ready, 0, "R8 full blocks");
    bus_rd(8'hD8, rd); chk(rd, 32'd16, "R7 rx level");
    bus_rd(8'h84, rd); chk(rd, 32'h4, "R9 high mark pending");
    bus_rd(8'hEC, rd); chk(rd, 32'd1, "R6 peek");
    bus_rd(8'hEC, rd); chk(rd, 32'd1, "R6 peek again");
    bus_rd(8'hD8, rd); chk(rd, 32'd16, "R6 peek keeps level");
    for (int i = 1; i <= 16; i++) begin
      bus_rd(8'hE8, rd); chk(rd, 32'(i), "R6 pop order");
    end
    bus_rd(8'hE8, rd); chk(rd, 32'd0, "R8 empty pop");
    bus_rd(8'hD8, rd); chk(rd, 32'd0, "R8 level after drain");

    // R11 sync capture, R10 set over clear
    bus_wr(8'h84, 32'hFF);
    @(negedge clk); sync_valid = 1; sync_id = 8'h5A;
    @(posedge clk); #1 sync_valid = 0;
    bus_rd(8'hC0, rd); chk(rd, 32'h5A, "R11 id");
    bus_rd(8'h84, rd); chk(rd, 32'h8, "R11 pending");
    @(negedge clk); sync_valid = 1; sync_id = 8'hC3;
    reg_wr = 1; reg_addr = 8'h84; reg_wdata = 32'hFF;
    @(posedge clk); #1 sync_valid = 0; reg_wr = 0;
    bus_rd(8'h84, rd); chk(rd, 32'h8, "R10 set wins");
    bus_rd(8'hC0, rd); chk(rd, 32'hC3, "R11 second id");

    // R3 hold flushes queues
    bus_wr(8'hE0, 32'h7777);
    bus_wr(8'hE4, 32'h11);
    @(negedge clk);
    chk(cmd_valid, 1, "R3 before hold");
    bus_wr(8'h40, 32'h1);
    repeat (2) @(negedge clk);
    chk(core_rst, 1, "R3 core_rst");
    chk(cmd_valid, 0, "R3 cmd flushed");
    chk(tx_valid, 0, "R3 tx flushed");
    chk(rx_ready, 0, "R3 rx blocked");
    bus_rd(8'hD0, rd); chk(rd, 32'd16, "R3 room restored");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule